// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Freeze Unit

This block holds the hazard decisions for a five-stage in-order pipeline. It looks at the two source register indices of the instruction now in the execute stage, together with a flag per operand that says whether that operand really reads a register. It also looks at the destination index and the write-enable and load flags of the instructions in the memory and writeback stages. From these it picks where each execute operand gets its value: the register file, the memory-stage result or the writeback-stage result. It also raises a freeze when a used operand needs a value that a load in the memory stage has not yet produced.

The logic is purely combinational, so the selects are ready in the same cycle as the stage contents. The operand-usage flags come from the decoder. An operand field that actually holds immediate bits, such as the upper bits of an add-immediate, has its flag cleared and can never start a forward or a freeze. Branch and jump address operands are presented through the same two operand paths, so they follow exactly the same rules. While the pipeline is frozen the memory stage receives a bubble. On the next cycle the load sits in writeback, and its value is then forwarded from there.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand select is 2'b01 (memory stage) when the operand is used, its index is nonzero, and it equals the memory-stage destination, provided the memory stage has its write enable set and is not a load.
- R2: An operand select is 2'b10 (writeback stage) when the operand is used, its index is nonzero, and it equals the writeback-stage destination with the writeback write enable set, and R1 does not apply.
- R3: When both the memory and writeback stages qualify under R1 and R2 for the same operand, the memory stage wins and the select is 2'b01.
- R4: A stage whose write enable is low is never chosen as a source and never causes a freeze, whatever its destination index.
- R5: An operand index of zero always gives select 2'b00 and never causes a freeze, even if a later stage writes register zero.
- R6: An operand whose usage flag is low gives select 2'b00 and never causes a freeze. An example is bits 24:20 of the add-immediate word 0x00a08093, which hold the value 10.
- R7: freeze is 1 exactly when some used operand with a nonzero index matches the destination of a memory-stage load that has its write enable set.
- R8: A load in the memory stage is never chosen as a source. An operand that waits on it takes 2'b10 if writeback qualifies, otherwise 2'b00.
- R9: A load in the writeback stage is forwarded like any other writeback result, so an operand that stalled on a load the cycle before gets select 2'b10.
- R10: The two operands are decided independently. Select value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register index of the execute-stage instruction |
| ex_src_b | input | REG_W | Second source register index of the execute-stage instruction |
| ex_use_a | input | 1 | First operand truly reads a register |
| ex_use_b | input | 1 | Second operand truly reads a register |
| mem_dst | input | REG_W | Destination index of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_W | Destination index of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_sel | output | 2 | Source for the first operand: 00 file, 01 memory, 10 writeback |
| fwd_b_sel | output | 2 | Source for the second operand, same encoding |
| freeze | output | 1 | Hold the front of the pipeline for a load-use dependency |

## Verification
Random vectors draw register indices from a small range, so both stages often match one or both operands at once. Under those collisions the bench checks stage priority, the effect of the write-enable and load flags, and that each operand is decided on its own. Directed cases cover patterns that random draws rarely produce. These include writes to register zero, the immediate field of an add-immediate word presented as an unused operand, and a load in memory matched by both operands. Sequences of back-to-back freezes check that, after each freeze, the cycle with the load in writeback forwards from writeback. That separates a correct stall release from one that keeps stalling or picks a stale source.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

    // Forwarding source encoding seen by the execute-stage operand muxes.
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MEM = 2'b01,
        SRC_WB  = 2'b10
    } fwd_src_e;

    // Match result of one operand against one producing stage.
    typedef struct packed {
        logic hit;
        logic ld;
    } stage_hit_t;

endpackage

// File: rtl/fwd_reg_match.sv
module fwd_reg_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic             src_used,
    input  logic [REG_W-1:0] dst_idx,
    input  logic             dst_wr,
    input  logic             dst_ld,
    output fwd_hazard_pkg::stage_hit_t match_o
);
    import fwd_hazard_pkg::*;

    stage_hit_t res_d;

    // A producer counts only for a real register read of a nonzero index.
    always_comb begin
        res_d     = '0;
        res_d.hit = src_used && dst_wr && (src_idx != '0) && (src_idx == dst_idx);
        res_d.ld  = res_d.hit && dst_ld;
    end

    assign match_o = res_d;

endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick (
    input  fwd_hazard_pkg::stage_hit_t mem_m,
    input  fwd_hazard_pkg::stage_hit_t wb_m,
    output logic [1:0]                 sel_o,
    output logic                       wait_o
);
    import fwd_hazard_pkg::*;

    typedef struct packed {
        fwd_src_e sel;
        logic     wait_ld;
    } pick_t;

    pick_t pick_d;

    // Younger producer first; a load still in memory has no data yet.
    always_comb begin
        pick_d.sel     = SRC_RF;
        pick_d.wait_ld = mem_m.ld;
        if (mem_m.hit && !mem_m.ld) begin
            pick_d.sel = SRC_MEM;
        end else if (wb_m.hit) begin
            pick_d.sel = SRC_WB;
        end
    end

    assign sel_o  = pick_d.sel;
    assign wait_o = pick_d.wait_ld;

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic             ex_use_a,
    input  logic             ex_use_b,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_ld,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             freeze
);
    import fwd_hazard_pkg::*;

    localparam int NUM_OPS = 2;

    logic [REG_W-1:0]   op_idx  [NUM_OPS];
    logic               op_used [NUM_OPS];
    logic [1:0]         op_sel  [NUM_OPS];
    logic [NUM_OPS-1:0] op_wait;

    assign op_idx[0]  = ex_src_a;
    assign op_idx[1]  = ex_src_b;
    assign op_used[0] = ex_use_a;
    assign op_used[1] = ex_use_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        stage_hit_t mem_m;
        stage_hit_t wb_m;

        fwd_reg_match #(.REG_W(REG_W)) u_mem_match (
            .src_idx  (op_idx[g]),
            .src_used (op_used[g]),
            .dst_idx  (mem_dst),
            .dst_wr   (mem_wr),
            .dst_ld   (mem_ld),
            .match_o  (mem_m)
        );

        // The writeback value is final even for a load.
        fwd_reg_match #(.REG_W(REG_W)) u_wb_match (
            .src_idx  (op_idx[g]),
            .src_used (op_used[g]),
            .dst_idx  (wb_dst),
            .dst_wr   (wb_wr),
            .dst_ld   (1'b0),
            .match_o  (wb_m)
        );

        fwd_src_pick u_pick (
            .mem_m  (mem_m),
            .wb_m   (wb_m),
            .sel_o  (op_sel[g]),
            .wait_o (op_wait[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];
    assign freeze    = |op_wait;

endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic             ex_use_a,
    input logic             ex_use_b,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wr,
    input logic             mem_ld,
    input logic [REG_W-1:0] wb_dst,
    input logic             wb_wr,
    input logic [1:0]       fwd_a_sel,
    input logic [1:0]       fwd_b_sel,
    input logic             freeze
);
    logic known;
    assign known = !$isunknown({ex_src_a, ex_src_b, ex_use_a, ex_use_b, mem_dst,
                                mem_wr, mem_ld, wb_dst, wb_wr, fwd_a_sel, fwd_b_sel, freeze});

    always_comb begin
        if (known) begin
            // R10: no reserved select code
            assert_sel_legal_R10: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
                else $error("select 11 seen");
            // R1 R4 R8: memory source only from a writing non-load with matching index
            assert_mem_src_R8: assert (fwd_a_sel != 2'b01 ||
                    (mem_wr && !mem_ld && ex_use_a && ex_src_a == mem_dst))
                else $error("bad memory source on operand a");
            assert_mem_src_b_R1: assert (fwd_b_sel != 2'b01 ||
                    (mem_wr && !mem_ld && ex_use_b && ex_src_b == mem_dst))
                else $error("bad memory source on operand b");
            // R2 R4: writeback source needs a writing producer with matching index
            assert_wb_src_R4: assert ((fwd_a_sel != 2'b10 || (wb_wr && ex_src_a == wb_dst)) &&
                    (fwd_b_sel != 2'b10 || (wb_wr && ex_src_b == wb_dst)))
                else $error("bad writeback source");
            // R5 R6: zero or unused operand reads the file
            assert_zero_unused_R6: assert (((ex_src_a != '0 && ex_use_a) || fwd_a_sel == 2'b00) &&
                    ((ex_src_b != '0 && ex_use_b) || fwd_b_sel == 2'b00))
                else $error("zero or unused operand forwarded");
            // R7: freeze only behind a writing load in memory
            assert_freeze_cause_R7: assert (!freeze || (mem_ld && mem_wr && mem_dst != '0))
                else $error("freeze without a memory-stage load");
        end
    end

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_W(REG_W)) u_chk (
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .ex_use_a  (ex_use_a),
    .ex_use_b  (ex_use_b),
    .mem_dst   (mem_dst),
    .mem_wr    (mem_wr),
    .mem_ld    (mem_ld),
    .wb_dst    (wb_dst),
    .wb_wr     (wb_wr),
    .fwd_a_sel (fwd_a_sel),
    .fwd_b_sel (fwd_b_sel),
    .freeze    (freeze)
);

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [REG_W-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
    logic ex_use_a = 1'b0, ex_use_b = 1'b0, mem_wr = 1'b0, mem_ld = 1'b0, wb_wr = 1'b0;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic freeze;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fwd_hazard_unit #(.REG_W(REG_W)) u_dut (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_use_a(ex_use_a), .ex_use_b(ex_use_b),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld), .wb_dst(wb_dst), .wb_wr(wb_wr),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .freeze(freeze)
    );

    // Reference source choice, written from the requirements.
    function automatic logic [1:0] ref_sel(logic [REG_W-1:0] s, logic u);
        logic live = u && (s != 0);
        if (!live) return 2'b00;                                    // R5 R6
        if (mem_wr && mem_dst == s && !mem_ld) return 2'b01;        // R1 R3
        if (wb_wr && wb_dst == s) return 2'b10;                     // R2 R8 R9
        return 2'b00;
    endfunction

    function automatic logic ref_frz();
        logic ha = ex_use_a && ex_src_a != 0 && ex_src_a == mem_dst;
        logic hb = ex_use_b && ex_src_b != 0 && ex_src_b == mem_dst;
        return mem_wr && mem_ld && (ha || hb);                      // R7
    endfunction

    task automatic check(string tag);
        logic [1:0] ea = ref_sel(ex_src_a, ex_use_a);
        logic [1:0] eb = ref_sel(ex_src_b, ex_use_b);
        logic ef = ref_frz();
        n_chk++;
        if (fwd_a_sel !== ea || fwd_b_sel !== eb || freeze !== ef) begin
            n_bad++;
            $display("FAIL %s: got a=%b b=%b frz=%b, expected a=%b b=%b frz=%b",
                     tag, fwd_a_sel, fwd_b_sel, freeze, ea, eb, ef);
        end
    endtask

    task automatic apply(string tag, int sa, int ua, int sb, int ub,
                         int md, int mw, int ml, int wd, int ww);
        @(posedge clk);
        ex_src_a = REG_W'(sa); ex_use_a = ua[0];
        ex_src_b = REG_W'(sb); ex_use_b = ub[0];
        mem_dst  = REG_W'(md); mem_wr = mw[0]; mem_ld = ml[0];
        wb_dst   = REG_W'(wd); wb_wr = ww[0];
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        logic [31:0] addi_word = 32'h00a08093;
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 reset state");
        rst_n = 1'b1;

        // Directed corner cases
        apply("R1 mem forward a",       3,1, 4,1,  3,1,0,  0,0);
        apply("R2 wb forward b",        3,1, 4,1,  0,1,0,  4,1);
        apply("R3 mem over wb",         6,1, 6,1,  6,1,0,  6,1);
        apply("R4 wen low ignored",     7,1, 7,1,  7,0,1,  7,0);
        apply("R5 zero reg written",    0,1, 0,1,  0,1,1,  0,1);
        apply("R6 addi immediate field", int'(addi_word[19:15]),1,
                                         int'(addi_word[24:20]),0,
                                         int'(addi_word[24:20]),1,1,
                                         int'(addi_word[24:20]),1);
        apply("R7 load use both ops",   9,1, 9,1,  9,1,1,  0,0);
        apply("R8 load in mem wb older",9,1, 2,1,  9,1,1,  9,1);
        apply("R9 after freeze from wb",9,1, 9,1,  0,0,0,  9,1);
        // R7 R9 repeated freezes: load, load, then dual dependency
        apply("R7 freeze 1",            5,1, 0,0,  5,1,1,  0,0);
        apply("R9 release 1",           5,1, 0,0,  0,0,0,  5,1);
        apply("R7 freeze 2",            8,1, 5,1,  8,1,1,  5,1);
        apply("R9 release 2",           8,1, 5,1,  0,0,0,  8,1);
        apply("R10 dual deps split",    8,1, 5,1,  8,1,0,  5,1);

        // Random vectors with crowded register indices
        for (int i = 0; i < 3000; i++) begin
            apply("R10 random",
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule